// File: doc/BRIEF.md
# Interrupt Control Register with Fixed-Priority Request

This block holds the eight-bit interrupt control word of a small microcontroller core. It latches event flags from three sources: a timer overflow pulse, an external pin with selectable edge, and a four-bit port-change detector. It also takes a level from a non-volatile write-complete source. It combines the enabled, pending sources into a single interrupt request. The request is gated by a global enable.

The core reads and writes the register through a plain register port. When the core accepts the request it pulses an acknowledge. The block then clears the global enable in that same edge, so no second interrupt can nest, and it presents a fixed service vector. A return pulse sets the global enable again. A priority code names the highest-ranked active source, so a handler can branch without polling every flag. The return-address stack and the instruction pipeline lie outside this block.

Top module: `irq_ctl_reg`

## Requirements
- R1: The register reads as {glb_en[7], ee_en[6], tmr_en[5], pin_en[4], chg_en[3], tmr_flag[2], pin_flag[1], chg_flag[0]}. A write stores all eight bits, and the stored value reads back on `rd_data` after the write edge.
- R2: A `tmr_ovf` pulse sets tmr_flag at the next clock edge, whatever the values of the enable bits and the global enable.
- R3: A flag is cleared only by a write that carries 0 in its bit position. With no write, a set flag stays set.
- R4: chg_flag sets at every edge where `port_hi` differs from a stored reference. A `port_rd` pulse copies `port_hi` into the reference. The reference resets to 0000.
- R5: pin_flag sets on a 0-to-1 change of `ext_pin` when `edge_rise` is 1, and on a 1-to-0 change when `edge_rise` is 0. The opposite change has no effect.
- R6: `irq_req` equals glb_en AND (tmr_en&tmr_flag OR pin_en&pin_flag OR chg_en&chg_flag OR ee_en&`ee_done`).
- R7: An `irq_ack` while `irq_req` is high clears glb_en at that edge, and `irq_req` drops. An `irq_ack` while `irq_req` is low has no effect.
- R8: An `irq_ret` pulse sets glb_en. An accepted acknowledge takes priority over a return and over a write. A return takes priority over a write.
- R9: When a write clears a flag in the same cycle that its source sets it, the flag ends up set.
- R10: After reset the register reads 00h and `irq_req` is low.
- R11: `irq_src` gives the highest-ranked active source while `irq_req` is high: 0 timer, 1 pin, 2 port change, 3 write-complete, with timer ranked highest. `irq_vec` reads 004h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register contents |
| tmr_ovf | input | 1 | Timer overflow pulse |
| ext_pin | input | 1 | External interrupt pin, already synchronous |
| edge_rise | input | 1 | 1 selects the rising edge, 0 selects the falling edge |
| port_hi | input | PORT_W | Watched port pins |
| port_rd | input | 1 | Port read strobe; refreshes the reference |
| ee_done | input | 1 | Write-complete level |
| irq_req | output | 1 | Interrupt request |
| irq_src | output | 2 | Highest-ranked active source code |
| irq_ack | input | 1 | Core accepts the request |
| irq_ret | input | 1 | Return from interrupt |
| irq_vec | output | PC_W | Service vector |

## Verification
Every flag and the global enable are registers. A stimulus applied before a clock edge therefore shows up on `rd_data` right after that edge. `irq_req` and `irq_src` are combinational from the register and `ee_done`, so they follow in the same cycle. The bench changes inputs on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge. Each expectation therefore targets the first register update after its stimulus. The request and priority code are swept over every combination of global enable, enables, flags and `ee_done`, and the expected values are computed from the R6 and R11 formulas.

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg #(
  parameter int PORT_W = 4,
  parameter int PC_W = 13,
  parameter logic [PC_W-1:0] VECTOR = 'h004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic              tmr_ovf,
  input  logic              ext_pin,
  input  logic              edge_rise,
  input  logic [PORT_W-1:0] port_hi,
  input  logic              port_rd,
  input  logic              ee_done,
  output logic              irq_req,
  output logic [1:0]        irq_src,
  input  logic              irq_ack,
  input  logic              irq_ret,
  output logic [PC_W-1:0]   irq_vec
);
  logic              gie;
  logic [3:0]        en;   // [3] ee, [2] tmr, [1] pin, [0] chg
  logic [2:0]        flg;  // [2] tmr, [1] pin, [0] chg
  logic              pin_q;
  logic [PORT_W-1:0] ref_q;

  wire       pin_edge = edge_rise ? (ext_pin & ~pin_q) : (~ext_pin & pin_q);
  wire       chg_hit  = (port_hi != ref_q);
  wire [2:0] hw_set   = {tmr_ovf, pin_edge, chg_hit};
  wire [3:0] pend     = {en[3] & ee_done, en[2] & flg[2], en[1] & flg[1], en[0] & flg[0]};
  wire       take     = irq_ack & irq_req;

  assign irq_req = gie & |pend;
  assign rd_data = {gie, en, flg};
  assign irq_vec = VECTOR;

  always_comb begin
    if (pend[2])      irq_src = 2'd0;
    else if (pend[1]) irq_src = 2'd1;
    else if (pend[0]) irq_src = 2'd2;
    else              irq_src = 2'd3;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie   <= 1'b0;
      en    <= '0;
      flg   <= '0;
      pin_q <= 1'b0;
      ref_q <= '0;
    end else begin
      if (take)         gie <= 1'b0;
      else if (irq_ret) gie <= 1'b1;
      else if (wr_en)   gie <= wr_data[7];
      if (wr_en) en <= wr_data[6:3];
      flg   <= (wr_en ? wr_data[2:0] : flg) | hw_set;
      pin_q <= ext_pin;
      if (port_rd) ref_q <= port_hi;
    end
  end

  p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((rd_data[2:0] & $past(rd_data[2:0])) == $past(rd_data[2:0])));
  p_tmr_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> rd_data[2]);
  p_chg_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (port_hi != ref_q) |=> rd_data[0]);
  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req) |=> !rd_data[7] && !irq_req);
  p_ret_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && !(irq_ack && irq_req)) |=> rd_data[7]);
  p_req_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[7] |-> !irq_req);
endmodule

// File: tb/irq_ctl_reg_tb.sv
module irq_ctl_reg_tb;
  logic clk = 0, rst_n = 0, wr_en = 0, tmr_ovf = 0, ext_pin = 0, edge_rise = 1;
  logic port_rd = 0, ee_done = 0, irq_ack = 0, irq_ret = 0;
  logic [7:0] wr_data = 0;
  logic [3:0] port_hi = 0;
  logic [7:0] rd_data;
  logic irq_req;
  logic [1:0] irq_src;
  logic [12:0] irq_vec;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_ctl_reg u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .tmr_ovf(tmr_ovf), .ext_pin(ext_pin), .edge_rise(edge_rise),
    .port_hi(port_hi), .port_rd(port_rd), .ee_done(ee_done), .irq_req(irq_req),
    .irq_src(irq_src), .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_vec(irq_vec));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] v);
    @(negedge clk); wr_en = 1; wr_data = v;
    @(negedge clk); wr_en = 0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset reg", rd_data, 8'h00);
    chk("R10 reset req", irq_req, 0);
    chk("R11 vector", irq_vec, 13'h004);

    // R1 R6 R11 sweep
    for (int g = 0; g < 2; g++)
      for (int e4 = 0; e4 < 16; e4++)
        for (int f = 0; f < 8; f++)
          for (int ee = 0; ee < 2; ee++) begin
            logic [7:0] v;
            logic [3:0] p;
            logic r;
            int s;
            v = {g[0], e4[3:0], f[2:0]};
            @(negedge clk); wr_en = 1; wr_data = v; ee_done = ee[0];
            @(negedge clk); wr_en = 0;
            p = {e4[3] & ee[0], e4[2] & f[2], e4[1] & f[1], e4[0] & f[0]};
            r = g[0] & (|p);
            s = p[2] ? 0 : p[1] ? 1 : p[0] ? 2 : 3;
            chk("R1 readback", rd_data, v);
            chk("R6 request", irq_req, r);
            if (r) chk("R11 source code", irq_src, s);
          end
    ee_done = 0;
    wr(8'h00);

    // R2 timer flag with all enables off
    @(negedge clk); tmr_ovf = 1;
    @(negedge clk); tmr_ovf = 0;
    chk("R2 timer flag set", rd_data, 8'h04);
    chk("R2 no request", irq_req, 0);
    repeat (3) @(negedge clk);
    chk("R3 flag sticky", rd_data, 8'h04);
    wr(8'h00);
    chk("R3 cleared by write", rd_data, 8'h00);

    // R9 set wins
    @(negedge clk); tmr_ovf = 1; wr_en = 1; wr_data = 8'h00;
    @(negedge clk); tmr_ovf = 0; wr_en = 0;
    chk("R9 set beats clear", rd_data[2], 1);
    wr(8'h00);

    // R5 edges
    edge_rise = 1;
    @(negedge clk); ext_pin = 1;
    @(negedge clk);
    chk("R5 rising sets", rd_data[1], 1);
    wr(8'h00);
    @(negedge clk); ext_pin = 0;
    @(negedge clk);
    chk("R5 falling ignored in rise mode", rd_data[1], 0);
    edge_rise = 0;
    @(negedge clk); ext_pin = 1;
    @(negedge clk);
    chk("R5 rising ignored in fall mode", rd_data[1], 0);
    @(negedge clk); ext_pin = 0;
    @(negedge clk);
    chk("R5 falling sets", rd_data[1], 1);
    wr(8'h00);

    // R4 port change
    @(negedge clk); port_hi = 4'b0101;
    @(negedge clk);
    chk("R4 change sets", rd_data[0], 1);
    wr(8'h00);
    chk("R4 mismatch persists", rd_data[0], 1);
    @(negedge clk); port_rd = 1;
    @(negedge clk); port_rd = 0;
    wr(8'h00);
    chk("R4 reference refreshed", rd_data[0], 0);
    @(negedge clk); port_hi = 4'b0100;
    @(negedge clk);
    chk("R4 single bit change", rd_data[0], 1);
    @(negedge clk); port_rd = 1;
    @(negedge clk); port_rd = 0;
    wr(8'h00);

    // R7 R8 acknowledge and return
    wr(8'hA4);
    chk("R6 request up", irq_req, 1);
    chk("R11 timer code", irq_src, 0);
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
    chk("R7 ack clears glb", rd_data, 8'h24);
    chk("R7 request drops", irq_req, 0);
    @(negedge clk); irq_ret = 1;
    @(negedge clk); irq_ret = 0;
    chk("R8 return sets glb", rd_data, 8'hA4);
    chk("R8 request back", irq_req, 1);
    @(negedge clk); irq_ack = 1; irq_ret = 1;
    @(negedge clk); irq_ack = 0; irq_ret = 0;
    chk("R8 ack beats return", rd_data[7], 0);
    wr(8'hA4);
    @(negedge clk); irq_ack = 1; wr_en = 1; wr_data = 8'hA4;
    @(negedge clk); irq_ack = 0; wr_en = 0;
    chk("R8 ack beats write", rd_data[7], 0);
    @(negedge clk); irq_ret = 1; wr_en = 1; wr_data = 8'h24;
    @(negedge clk); irq_ret = 0; wr_en = 0;
    chk("R8 return beats write", rd_data[7], 1);
    wr(8'h80);
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
    chk("R7 ack without request ignored", rd_data, 8'h80);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule